// File: doc/BRIEF.md
# Clamp-Referenced Digital Gain Stage

The block applies a programmable digital gain to three parallel video channels. Each gain is centred on a programmable black level rather than on zero. Each valid sample is first reduced to 10 bits. The clamp level is then subtracted from it, the signed difference is scaled by an unsigned fixed-point gain, and the clamp level is added back. The result is rounded and limited to the 10-bit unsigned output range. A sample that sits exactly on the clamp level therefore leaves the block unchanged whatever gain is programmed.

The gain and clamp values arrive on plain register inputs and are copied into internal shadow registers. When synchronised mode is off, the copy happens on every clock. When it is on, the copy happens only on clocks where the sync input is low. Setting changes can therefore be confined to the region outside active video. Results appear two clocks after their input sample, with a matching valid flag.

Top module: `clamp_gain_stage`

## Requirements
- R1: Each output equals clamp + floor((d*g + 256) / 512), where d = x - clamp is signed, x is the reduced sample and g is the raw 12-bit gain register value (rounding half up).
- R2: The gain register is unsigned 3.9 fixed point (bits 11:9 integer, bits 8:0 in 1/512 units). The value 0x200 (gain 1.0) passes the reduced sample through unchanged.
- R3: The clamp level is the 8-bit clamp register shifted left by two (10 bits, low two bits zero). A sample equal to the clamp level leaves unchanged for any gain.
- R4: Results below 0 saturate to 0 and results above 1023 saturate to 1023.
- R5: After reset the active gain is 0x400 (2.0), the active clamp is 0, valid_o is low and every data output is 0.
- R6: valid_o is high exactly two clocks after valid_i was high. Data outputs change only for valid samples and hold otherwise.
- R7: With sync_mode_i low, register values present at a clock edge are used for samples taken at the following edge onward, and not for samples taken at that same edge.
- R8: With sync_mode_i high, the shadow registers load only at edges where sync_i is low. While sync_i is high, register input changes have no effect on the output.
- R9: The three channels are processed independently, each with the same active gain and clamp.
- R10: Only sample bits 11:2 are used. Bits 1:0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | 36 | Channel k sample at bits [12k+11:12k] |
| clamp_reg_i | input | 8 | Clamp level register value |
| gain_reg_i | input | 12 | Gain register value, 3.9 fixed point |
| sync_mode_i | input | 1 | 1: settings load only while sync_i is low |
| sync_i | input | 1 | Active-video indicator, high inside active video |
| data_o | output | 30 | Channel k result at bits [10k+9:10k] |
| valid_o | output | 1 | Result strobe |

## Verification
The bench builds the block with its default parameters: three channels, 12-bit samples, 10-bit results, an 8-bit clamp and a 3.9 gain. With these values every corner is reachable with a few directed samples. Half-way rounding on both signs of the difference is reached through gain 1.5. Both saturation rails are reached through gain 2 with a high clamp, and the clamp pivot is reached at maximum gain. Dropped sample LSBs are checked with 0xFFF against 0xFFC. The full 3.9 gain range also exercises the widest product, so overflow of the intermediate width shows up at the outputs.

// File: rtl/clamp_gain_pkg.sv
package clamp_gain_pkg;
  localparam int unsigned NUM_CH_D    = 3;
  localparam int unsigned SMP_W_D     = 12;
  localparam int unsigned DAT_W_D     = 10;
  localparam int unsigned CLP_W_D     = 8;
  localparam int unsigned GAIN_W_D    = 12;
  localparam int unsigned GAIN_FRAC_D = 9;
  localparam int unsigned LAT_D       = 2;
  localparam logic [GAIN_W_D-1:0] GAIN_RST_D = 12'h400;

  typedef enum logic {
    LOAD_FREE = 1'b0,
    LOAD_SYNC = 1'b1
  } load_mode_e;
endpackage

// File: rtl/cg_shadow_regs.sv
module cg_shadow_regs
  import clamp_gain_pkg::*;
#(
  parameter int unsigned CLP_W    = CLP_W_D,
  parameter int unsigned DAT_W    = DAT_W_D,
  parameter int unsigned GAIN_W   = GAIN_W_D,
  parameter logic [GAIN_W-1:0] GAIN_RST = GAIN_RST_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CLP_W-1:0]  clamp_reg_i,
  input  logic [GAIN_W-1:0] gain_reg_i,
  input  logic              mode_i,
  input  logic              sync_i,
  output logic [DAT_W-1:0]  clamp_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned PAD_W = DAT_W - CLP_W;

  load_mode_e       mode;
  logic             load;
  logic [CLP_W-1:0] clamp_q;

  assign mode = load_mode_e'(mode_i);
  // sync high marks active video: hold settings there when synchronised
  assign load = (mode == LOAD_FREE) || !sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_q <= '0;
      gain_o  <= GAIN_RST;
    end else if (load) begin
      clamp_q <= clamp_reg_i;
      gain_o  <= gain_reg_i;
    end
  end

  assign clamp_o = {clamp_q, {PAD_W{1'b0}}};

  AST_FREE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (gain_o == $past(gain_reg_i)) && (clamp_o[DAT_W-1 -: CLP_W] == $past(clamp_reg_i))); // R7
  AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && sync_i) |=> ($stable(gain_o) && $stable(clamp_o))); // R8
endmodule

// File: rtl/cg_valid_pipe.sv
module cg_valid_pipe
  import clamp_gain_pkg::*;
#(
  parameter int unsigned DEPTH = LAT_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] stage_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic d;
    if (s == 0) begin : g_head
      assign d = valid_i;
    end else begin : g_tail
      assign d = stage_o[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_o[s] <= 1'b0;
      else         stage_o[s] <= d;
    end
  end
endmodule

// File: rtl/cg_lane.sv
module cg_lane
  import clamp_gain_pkg::*;
#(
  parameter int unsigned SMP_W     = SMP_W_D,
  parameter int unsigned DAT_W     = DAT_W_D,
  parameter int unsigned GAIN_W    = GAIN_W_D,
  parameter int unsigned GAIN_FRAC = GAIN_FRAC_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en0_i,
  input  logic              en1_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [DAT_W-1:0]  clamp_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DAT_W-1:0]  dat_o
);
  localparam int unsigned DIF_W  = DAT_W + 1;
  localparam int unsigned PROD_W = DIF_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND_K = PROD_W'(2 ** (GAIN_FRAC - 1));
  localparam logic signed [PROD_W-1:0] TOP_K = PROD_W'(2 ** DAT_W - 1);

  logic [DAT_W-1:0]         smp_x;
  logic signed [DIF_W-1:0]  diff;
  logic signed [PROD_W-1:0] diff_ext, gain_ext, prod;
  logic signed [PROD_W-1:0] prod_q;
  logic [DAT_W-1:0]         clamp_q;
  logic signed [PROD_W-1:0] scaled, sum;
  logic [DAT_W-1:0]         sat;

  assign smp_x = smp_i[SMP_W-1 -: DAT_W];
  if (SMP_W > DAT_W) begin : g_lsb
    logic unused_lsb;
    assign unused_lsb = ^smp_i[SMP_W-DAT_W-1:0];
  end

  // stage 1: pivot around clamp, full-precision product
  assign diff     = $signed({1'b0, smp_x}) - $signed({1'b0, clamp_i});
  assign diff_ext = PROD_W'(diff);
  assign gain_ext = $signed({{(PROD_W-GAIN_W){1'b0}}, gain_i});
  assign prod     = diff_ext * gain_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      clamp_q <= '0;
    end else if (en0_i) begin
      prod_q  <= prod;
      clamp_q <= clamp_i;
    end
  end

  // stage 2: round half up, restore pivot, saturate
  assign scaled = (prod_q + RND_K) >>> GAIN_FRAC;
  assign sum    = scaled + $signed({{(PROD_W-DAT_W){1'b0}}, clamp_q});

  always_comb begin
    if (sum < 0)          sat = '0;
    else if (sum > TOP_K) sat = '1;
    else                  sat = sum[DAT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dat_o <= '0;
    else if (en1_i) dat_o <= sat;
  end

  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && gain_i == GAIN_W'(2 ** GAIN_FRAC)) |-> ##2 (dat_o == $past(smp_x, 2))); // R2
  AST_PIVOT_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en0_i && smp_x == clamp_i) |-> ##2 (dat_o == $past(clamp_i, 2))); // R3
  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en1_i && sum < 0) |=> (dat_o == '0)); // R4
  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en1_i && sum > TOP_K) |=> (dat_o == '1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en1_i |=> $stable(dat_o)); // R6
endmodule

// File: rtl/clamp_gain_stage.sv
module clamp_gain_stage
  import clamp_gain_pkg::*;
#(
  parameter int unsigned NUM_CH    = NUM_CH_D,
  parameter int unsigned SMP_W     = SMP_W_D,
  parameter int unsigned DAT_W     = DAT_W_D,
  parameter int unsigned CLP_W     = CLP_W_D,
  parameter int unsigned GAIN_W    = GAIN_W_D,
  parameter int unsigned GAIN_FRAC = GAIN_FRAC_D,
  parameter logic [GAIN_W-1:0] GAIN_RST = GAIN_RST_D
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [NUM_CH*SMP_W-1:0]   sample_i,
  input  logic [CLP_W-1:0]          clamp_reg_i,
  input  logic [GAIN_W-1:0]         gain_reg_i,
  input  logic                      sync_mode_i,
  input  logic                      sync_i,
  output logic [NUM_CH*DAT_W-1:0]   data_o,
  output logic                      valid_o
);
  localparam int unsigned LAT = LAT_D;

  logic [DAT_W-1:0]  clamp_act;
  logic [GAIN_W-1:0] gain_act;
  logic [LAT-1:0]    vstage;

  cg_shadow_regs #(
    .CLP_W(CLP_W), .DAT_W(DAT_W), .GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)
  ) u_shadow (
    .clk_i, .rst_ni,
    .clamp_reg_i, .gain_reg_i,
    .mode_i (sync_mode_i),
    .sync_i,
    .clamp_o(clamp_act),
    .gain_o (gain_act)
  );

  cg_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk_i, .rst_ni, .valid_i,
    .stage_o(vstage)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cg_lane #(
      .SMP_W(SMP_W), .DAT_W(DAT_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_lane (
      .clk_i, .rst_ni,
      .en0_i  (valid_i),
      .en1_i  (vstage[0]),
      .smp_i  (sample_i[c*SMP_W +: SMP_W]),
      .clamp_i(clamp_act),
      .gain_i (gain_act),
      .dat_o  (data_o[c*DAT_W +: DAT_W])
    );
  end

  assign valid_o = vstage[LAT-1];

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o); // R6
endmodule

// File: tb/clamp_gain_stage_test.sv
module clamp_gain_stage_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [35:0] sample_i = '0;
  logic [7:0]  clamp_reg_i = '0;
  logic [11:0] gain_reg_i = '0;
  logic        sync_mode_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [29:0] data_o;
  logic        valid_o;

  int n_chk = 0, n_fail = 0;
  int act_clamp = 0, act_gain = 'h400;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  clamp_gain_stage uut (.*);

  function automatic int model(int s12, int clamp8, int gain);
    int x, c, r;
    x = s12 >>> 2;
    c = clamp8 << 2;
    r = c + (((x - c) * gain + 256) >>> 9);
    if (r < 0) r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_regs(int clamp8, int gain);
    @(negedge clk_i);
    clamp_reg_i = clamp8[7:0];
    gain_reg_i  = gain[11:0];
    if (!sync_mode_i || !sync_i) begin
      act_clamp = clamp8;
      act_gain  = gain;
    end
  endtask

  task automatic push(string req, int a, int b, int c);
    @(negedge clk_i);
    sample_i = {c[11:0], b[11:0], a[11:0]};
    valid_i  = 1'b1;
    @(negedge clk_i);
    valid_i  = 1'b0;
    chk({req, " R6 mid"}, int'(valid_o), 0);
    @(negedge clk_i);
    chk({req, " R6 valid"}, int'(valid_o), 1);
    chk({req, " ch0"}, int'(data_o[9:0]),   model(a, act_clamp, act_gain));
    chk({req, " ch1"}, int'(data_o[19:10]), model(b, act_clamp, act_gain));
    chk({req, " ch2"}, int'(data_o[29:20]), model(c, act_clamp, act_gain));
  endtask

  task automatic t_reset;
    chk("R5 valid", int'(valid_o), 0);
    chk("R5 data", int'(data_o), 0);
    push("R5 default gain", 300 << 2, 100 << 2, 600 << 2);
  endtask

  task automatic t_rounding;
    set_regs(0, 'h300);
    push("R1 round pos", 3 << 2, 5 << 2, 1000 << 2);
    set_regs(100, 'h300);
    push("R1 round neg", 399 << 2, 397 << 2, 0);
  endtask

  task automatic t_unity;
    set_regs(37, 'h200);
    push("R2 unity", 0, 513 << 2, 1023 << 2);
    chk("R2 unity exact", int'(data_o[19:10]), 513);
  endtask

  task automatic t_pivot;
    set_regs(200, 'hFFF);
    push("R3 pivot max gain", 800 << 2, 800 << 2, 801 << 2);
    chk("R3 pivot exact", int'(data_o[9:0]), 800);
    set_regs(200, 0);
    push("R3 zero gain", 5 << 2, 1023 << 2, 800 << 2);
  endtask

  task automatic t_saturate;
    set_regs(200, 'h400);
    push("R4 sat", 0, 1023 << 2, 500 << 2);
    chk("R4 low rail", int'(data_o[9:0]), 0);
    chk("R4 high rail", int'(data_o[19:10]), 1023);
  endtask

  task automatic t_lsb_and_hold;
    logic [29:0] held;
    set_regs(10, 'h2A7);
    push("R10 lsb", 'hFFF, 'hFFC, 'h801);
    chk("R10 ignored", int'(data_o[9:0]), int'(data_o[19:10]));
    held = data_o;
    sample_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R6 hold", int'(data_o), int'(held));
  endtask

  task automatic t_free_load;
    int old_g;
    set_regs(0, 'h200);
    old_g = act_gain;
    @(negedge clk_i);
    gain_reg_i = 12'h400;
    sample_i   = {12'd0, 12'd0, 12'(100 << 2)};
    valid_i    = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R7 same edge old", int'(data_o[9:0]), model(100 << 2, 0, old_g));
    act_gain = 'h400;
    push("R7 next edge new", 100 << 2, 7 << 2, 400 << 2);
  endtask

  task automatic t_sync_load;
    set_regs(0, 'h200);
    @(negedge clk_i);
    sync_mode_i = 1'b1;
    sync_i      = 1'b1;
    set_regs(50, 'h600);
    push("R8 held in active", 300 << 2, 200 << 2, 1 << 2);
    chk("R8 old gain", int'(data_o[9:0]), 300);
    @(negedge clk_i);
    sync_i = 1'b0;
    @(negedge clk_i);
    sync_i = 1'b1;
    act_clamp = 50;
    act_gain  = 'h600;
    push("R8 loaded in blank", 300 << 2, 200 << 2, 1 << 2);
    sync_mode_i = 1'b0;
  endtask

  task automatic t_channels;
    set_regs(64, 'h355);
    push("R9 channels", 12 << 2, 700 << 2, 256 << 2);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    gain_reg_i  = 12'h155;
    clamp_reg_i = 8'd90;
    sync_mode_i = 1'b1;
    sync_i      = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    sync_mode_i = 1'b0;
    sync_i      = 1'b0;
    t_rounding;
    t_unity;
    t_pivot;
    t_saturate;
    t_lsb_and_hold;
    t_free_load;
    t_sync_load;
    t_channels;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule